// File: doc/BRIEF.md
# Biphase-Mark Consumer Audio Frame Encoder

This block turns a stream of stereo or mono PCM sample pairs into a single-wire consumer digital audio bitstream. It runs from a cell clock at 128 times the sample rate. Each frame holds two subframes, A then B, of 32 slots, and each slot takes two clock cycles (cells). A subframe starts with a four-slot sync preamble. Slots 4 to 27 carry the audio sample, and slots 28 to 31 carry the validity, user, channel-status and parity bits. Every data slot is biphase-mark coded onto the output pin `sdo`.

Samples arrive through a valid/ready handshake into a one-entry holding register. The transmit side takes the held pair on the first cell of each frame. Each channel has its own 192-bit channel-status image, sent one bit per frame across a 192-frame block. Validity, user and channel-status bits each come either from a manual source or from flags that travel with the sample. Mute works by forcing the validity bit high, not by clearing samples.

There are two asynchronous resets, one for the transmit side and one for the sample-input side, and a run enable. Release the transmit reset first, then the input reset, and set the enable last.

Top module: `spdif_tx_encoder`

## Requirements
- R1: While `rst_out_n` is low, `sdo` is 0. While `rst_in_n` is low, `smp_ready` is 0 and any held sample is discarded.
- R2: One frame is 128 cycles: subframe A, then subframe B, each of 32 slots of two cells. In every data slot (4 to 31), `sdo` toggles at the first cell, and toggles again at the second cell only when the slot's bit is 1.
- R3: Slots 0 to 3 carry an 8-cell preamble, sent first cell first. Subframe A of frame 0 uses 11101000, subframe A of any other frame uses 11100010, and subframe B uses 11100100. The whole pattern is inverted when the line was high just before it.
- R4: A frame counter runs from 0 to 191. The frame after 191 is frame 0 again.
- R5: The SW-bit sample fills slots 4 to 27 with its MSB in slot 27 and zeros in the unused low slots, sent LSB first when `msb_first` is 0. When `msb_first` is 1, that 24-slot field is sent in reverse order, so the MSB is in slot 4.
- R6: Slot 28 (V) is `v_man` when `v_sel` is 0, and the pair's `smp_v` flag when `v_sel` is 1. With `v_sel`=0 and `v_man`=1, every subframe is marked invalid (mute).
- R7: Slot 29 (U) is `u_man` when `u_sel` is 0, and the pair's `smp_u` flag when `u_sel` is 1.
- R8: Slot 30 (C) in frame n is bit n of `cs_a` (subframe A) or of `cs_b` (subframe B) when `c_sel` is 0. Status word k, bits 0 to 31, maps to image bits 32k to 32k+31. When `c_sel` is 1, slot 30 is the pair's `smp_c` flag.
- R9: Slot 31 holds even parity over slots 4 to 30, so the line ends each subframe at the level it had just before that subframe's preamble.
- R10: While `en` is low, `sdo` is 0 and the frame position is held at frame 0, subframe A, cell 0. The first clock edge with `en` high drives cell 0.
- R11: The holding register accepts a pair on an edge where `smp_valid` and `smp_ready` are both high. `smp_ready` is high only when the input reset is released and the register is empty. The held pair is taken on the edge that drives cell 0 of a frame. If the register is empty at that edge, the frame carries a zero sample with zero V, U and C flags.
- R12: When `mono` is 1 at the take edge, subframe B carries the channel-A sample and the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, 128 × sample rate |
| rst_out_n | input | 1 | Asynchronous active-low reset, transmit side |
| rst_in_n | input | 1 | Asynchronous active-low reset, sample input side |
| en | input | 1 | Run enable |
| smp_a | input | SW | Channel A sample |
| smp_b | input | SW | Channel B sample |
| smp_v | input | 1 | Data-path validity flag for the pair |
| smp_u | input | 1 | Data-path user flag for the pair |
| smp_c | input | 1 | Data-path channel-status flag for the pair |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding register can accept a pair |
| mono | input | 1 | Send channel A in both subframes |
| msb_first | input | 1 | Reverse the audio field slot order |
| v_sel | input | 1 | 1: V from data path, 0: V from v_man |
| v_man | input | 1 | Manual V value |
| u_sel | input | 1 | 1: U from data path, 0: U from u_man |
| u_man | input | 1 | Manual U value |
| c_sel | input | 1 | 1: C from data path, 0: C from status image |
| cs_a | input | 192 | Channel-status image for subframe A |
| cs_b | input | 192 | Channel-status image for subframe B |
| sdo | output | 1 | Biphase-mark coded serial output |

## Verification
The hardest case to reach is the wrap from frame 191 to frame 0, where the B preamble must come back. It appears only after a full 24,576-cycle block of steady traffic, so the first phase streams pairs without a gap for more than 192 frames. Later phases clear the enable to force a restart at frame 0. An underrun is made by withdrawing `smp_valid` across several frames. The input reset is pulsed while a pair is held, so that the take edge finds the register emptied.

// File: rtl/spdif_tx_encoder.sv
module spdif_tx_encoder #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_out_n,
  input  logic          rst_in_n,
  input  logic          en,
  input  logic [SW-1:0] smp_a,
  input  logic [SW-1:0] smp_b,
  input  logic          smp_v,
  input  logic          smp_u,
  input  logic          smp_c,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic          mono,
  input  logic          msb_first,
  input  logic          v_sel,
  input  logic          v_man,
  input  logic          u_sel,
  input  logic          u_man,
  input  logic          c_sel,
  input  logic [191:0]  cs_a,
  input  logic [191:0]  cs_b,
  output logic          sdo
);
  localparam int FRAMES = 192;
  localparam int FW     = $clog2(FRAMES);
  localparam int AW     = 24;
  localparam int PAD    = AW - SW;

  logic          full;
  logic [SW-1:0] h_a, h_b, c_a, c_b;
  logic [2:0]    h_f, c_f;
  logic [6:0]    pos;
  logic [FW-1:0] frame;
  logic          base;

  wire       sub  = pos[6];
  wire [4:0] slot = pos[5:1];
  wire       half = pos[0];
  wire [2:0] ci   = pos[2:0];
  wire       pre  = (pos[5:3] == 3'd0);
  wire       take = rst_out_n && en && (pos == 7'd0);

  assign smp_ready = rst_in_n && !full;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      full <= 1'b0;
      h_a  <= '0;
      h_b  <= '0;
      h_f  <= '0;
    end else if (smp_valid && !full) begin
      full <= 1'b1;
      h_a  <= smp_a;
      h_b  <= smp_b;
      h_f  <= {smp_v, smp_u, smp_c};
    end else if (take && full) begin
      full <= 1'b0;
    end
  end

  logic [SW-1:0] smp;
  logic [AW-1:0] aligned, field;
  logic          vb, ub, cb, par, bitv, base_w, pre_bit, nxt;
  logic [26:0]   body;
  logic [31:0]   word;
  logic [7:0]    pat;

  assign smp     = sub ? c_b : c_a;
  assign aligned = AW'(smp) << PAD;

  always_comb
    for (int i = 0; i < AW; i++)
      field[i] = msb_first ? aligned[AW-1-i] : aligned[i];

  assign vb   = v_sel ? c_f[2] : v_man;
  assign ub   = u_sel ? c_f[1] : u_man;
  assign cb   = c_sel ? c_f[0] : (sub ? cs_b[frame] : cs_a[frame]);
  assign body = {cb, ub, vb, field};
  assign par  = ^body;
  assign word = {par, body, 4'b0000};
  assign bitv = word[slot];

  assign pat     = sub ? 8'b11100100 : ((frame == '0) ? 8'b11101000 : 8'b11100010);
  assign base_w  = (ci == 3'd0) ? sdo : base;
  assign pre_bit = pat[3'd7 - ci] ^ base_w;
  assign nxt     = pre ? pre_bit : (half ? (sdo ^ bitv) : ~sdo);

  always_ff @(posedge clk or negedge rst_out_n) begin
    if (!rst_out_n) begin
      sdo   <= 1'b0;
      pos   <= '0;
      frame <= '0;
      base  <= 1'b0;
      c_a   <= '0;
      c_b   <= '0;
      c_f   <= '0;
    end else if (!en) begin
      sdo   <= 1'b0;
      pos   <= '0;
      frame <= '0;
    end else begin
      sdo <= nxt;
      pos <= pos + 7'd1;
      if (pre) base <= base_w;
      if (pos == 7'd127)
        frame <= (frame == FW'(FRAMES - 1)) ? '0 : frame + 1'b1;
      if (pos == 7'd0) begin
        c_a <= full ? h_a : '0;
        c_b <= full ? (mono ? h_a : h_b) : '0;
        c_f <= full ? h_f : 3'b000;
      end
    end
  end
endmodule

// File: rtl/spdif_tx_encoder_chk.sv
module spdif_tx_encoder_chk #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_out_n,
  input logic          rst_in_n,
  input logic          en,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          sdo,
  input logic [6:0]    pos,
  input logic [FW-1:0] frame,
  input logic          base
);
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_out_n)
    !en |=> !sdo);

  assert_ready_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_out_n)
    !rst_in_n |-> !smp_ready);

  assert_cell_toggle_R2: assert property (@(posedge clk) disable iff (!rst_out_n)
    (en && pos[5:1] >= 5'd4 && !pos[0]) |=> (sdo != $past(sdo)));

  assert_level_return_R9: assert property (@(posedge clk) disable iff (!rst_out_n)
    (en && pos[5:0] == 6'd63) |=> (sdo == base));

  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_out_n)
    (en && pos == 7'd127 && frame == FW'(191)) |=> (frame == '0));

  assert_single_entry_R11: assert property (@(posedge clk) disable iff (!rst_in_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

bind spdif_tx_encoder spdif_tx_encoder_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_out_n(rst_out_n), .rst_in_n(rst_in_n), .en(en),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .sdo(sdo),
  .pos(pos), .frame(frame), .base(base)
);

// File: tb/spdif_tx_encoder_bench.sv
`timescale 1ns/1ps
module spdif_tx_encoder_bench;
  localparam int SW = 20;

  logic clk = 0, rst_out_n = 0, rst_in_n = 0, en = 0;
  logic [SW-1:0] smp_a = '0, smp_b = '0;
  logic smp_v = 0, smp_u = 0, smp_c = 0, smp_valid = 0;
  logic smp_ready, sdo;
  logic mono = 0, msb_first = 0, v_sel = 1, v_man = 0, u_sel = 1, u_man = 0, c_sel = 0;
  logic [191:0] cs_a, cs_b;

  int checks = 0, errors = 0, cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spdif_tx_encoder #(.SW(SW)) u_spdif_tx_encoder (
    .clk(clk), .rst_out_n(rst_out_n), .rst_in_n(rst_in_n), .en(en),
    .smp_a(smp_a), .smp_b(smp_b), .smp_v(smp_v), .smp_u(smp_u), .smp_c(smp_c),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .mono(mono), .msb_first(msb_first),
    .v_sel(v_sel), .v_man(v_man), .u_sel(u_sel), .u_man(u_man), .c_sel(c_sel),
    .cs_a(cs_a), .cs_b(cs_b), .sdo(sdo));

  initial begin
    for (int k = 0; k < 6; k++) begin
      cs_a[32*k +: 32] = 32'hA5C3_0F17 ^ (32'h0101_0101 * k);
      cs_b[32*k +: 32] = 32'h3C96_E12B + (32'h0011_2233 * k);
    end
  end

  // behavioural reference model
  int m_pos = 0, m_frame = 0;
  bit m_line = 0, m_base = 0, m_full = 0, m_took = 0;
  logic [23:0] h_a = 0, h_b = 0, k_a = 0, k_b = 0;
  logic [2:0] h_f = 0, k_f = 0;
  string tag = "R1";

  function automatic logic [31:0] exp_word(bit sb);
    logic [23:0] al;
    logic [31:0] w;
    bit p;
    al = (sb ? k_b : k_a) << (24 - SW);
    w = 0;
    for (int i = 0; i < 24; i++) w[4+i] = msb_first ? al[23-i] : al[i];
    w[28] = v_sel ? k_f[2] : v_man;
    w[29] = u_sel ? k_f[1] : u_man;
    w[30] = c_sel ? k_f[0] : (sb ? cs_b[m_frame] : cs_a[m_frame]);
    p = 0;
    for (int i = 4; i <= 30; i++) p ^= w[i];
    w[31] = p;
    return w;
  endfunction

  always @(posedge clk) begin
    automatic bit ofull = m_full && rst_in_n;
    automatic bit tk = rst_out_n && en && (m_pos == 0);
    m_took = 0;
    if (!rst_out_n) begin
      m_line = 0; m_pos = 0; m_frame = 0; tag = "R1";
    end else if (!en) begin
      m_line = 0; m_pos = 0; m_frame = 0; tag = "R10";
    end else begin
      automatic int sb = m_pos / 64;
      automatic int sl = (m_pos / 2) % 32;
      automatic int hf = m_pos % 2;
      if (m_pos == 0) begin
        k_a = ofull ? h_a : 0;
        k_b = ofull ? (mono ? h_a : h_b) : 0;
        k_f = ofull ? h_f : 0;
      end
      if (sl < 4) begin
        automatic int c = m_pos % 8;
        automatic logic [7:0] pt = sb ? 8'b11100100 : (m_frame == 0 ? 8'b11101000 : 8'b11100010);
        if (c == 0) m_base = m_line;
        m_line = pt[7-c] ^ m_base;
        tag = (m_frame == 0 && sb == 0) ? "R3/R4" : "R3";
      end else begin
        automatic logic [31:0] w = exp_word(sb[0]);
        m_line = hf ? (m_line ^ w[sl]) : ~m_line;
        if (sl <= 27) tag = (sb == 1 && mono) ? "R5/R12" : "R5/R11";
        else if (sl == 28) tag = "R6";
        else if (sl == 29) tag = "R7";
        else if (sl == 30) tag = "R8";
        else tag = "R9/R2";
      end
      if (m_pos == 127) m_frame = (m_frame + 1) % 192;
      m_pos = (m_pos + 1) % 128;
    end
    if (!rst_in_n) m_full = 0;
    else if (smp_valid && !ofull) begin
      m_full = 1; h_a = 24'(smp_a); h_b = 24'(smp_b); h_f = {smp_v, smp_u, smp_c}; m_took = 1;
    end else if (tk && ofull) m_full = 0;
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      checks++;
      if (sdo !== m_line) begin
        errors++;
        $display("FAIL %s sdo actual %b expected %b (frame %0d pos %0d)", tag, sdo, m_line, m_frame, m_pos);
      end
      checks++;
      if (smp_ready !== (rst_in_n && !m_full)) begin
        errors++;
        $display("FAIL %s smp_ready actual %b expected %b", rst_in_n ? "R11" : "R1",
                 smp_ready, rst_in_n && !m_full);
      end
    end
  end

  // sample source: new pair after each accepted one
  always @(negedge clk) begin
    if (m_took) begin
      cnt++;
      smp_a <= SW'(cnt * 32'h9E37_79B1 >> 5);
      smp_b <= SW'(cnt * 32'h85EB_CA6B >> 3);
      {smp_v, smp_u, smp_c} <= 3'(cnt ^ (cnt >> 3));
    end
  end

  task automatic wait_frames(int n);
    repeat (n * 128) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state is checked by the per-clock comparison above
    rst_out_n = 1;
    repeat (3) @(negedge clk);
    rst_in_n = 1;
    @(negedge clk);
    smp_a = SW'(20'h12345); smp_b = SW'(20'hABCDE);
    smp_valid = 1;
    repeat (2) @(negedge clk);
    en = 1;
    // R4, R3: run past one full 192-frame block
    wait_frames(200);
    // R6 mute and R5 reversed order
    v_sel = 0; v_man = 1; msb_first = 1;
    wait_frames(12);
    // R12 mono, R8 data-path C, R7 manual U
    v_man = 0; mono = 1; c_sel = 1; u_sel = 0; u_man = 1;
    wait_frames(12);
    // R11 underrun
    mono = 0; msb_first = 0; smp_valid = 0;
    wait_frames(6);
    smp_valid = 1;
    wait_frames(4);
    // R1 input reset pulse mid-frame while a pair is held
    repeat (40) @(negedge clk);
    rst_in_n = 0;
    repeat (10) @(negedge clk);
    rst_in_n = 1;
    wait_frames(4);
    // R10 enable off, then restart at frame 0
    en = 0;
    repeat (50) @(negedge clk);
    en = 1; c_sel = 0; v_sel = 1; u_sel = 1;
    wait_frames(6);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    finished = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule